// File: doc/BRIEF.md
# Multiprocessor Run-Control and Inter-Processor Interrupt Unit

This block sits on a shared register port used by a small cluster of processors (four by default). Every access carries the id of the processor making it. Software uses the block in three ways. It can ask which processor it is running on and how many processors exist. It can hand out a common boot address and boot stack, then release, hold or resume individual processors. It can post inter-processor interrupt numbers into per-processor queues, which the receiving processor drains one entry at a time.

Each processor owns an 8-entry queue of 16-bit interrupt numbers. The processor's interrupt line stays high while its queue is not empty. The number 0 is reserved to mean "nothing pending", so a send carrying 0 does nothing. A send to a full queue is dropped and sets that processor's sticky overflow flag. A flush by the owning processor clears the flag. The block also keeps a per-processor count of the cycles in which that processor was allowed to run.

Register offsets are byte offsets on an 8-bit offset bus. Only offsets whose low four bits are zero are decoded. Register index = offset bits [7:4].

Top module: `mp_ctrl`

## Requirements
- R1: A read at offset 0x00 returns the requesting id, and a read at 0x10 returns NUM_CPU. A read of any offset that is not decoded returns 0; this includes offsets with a nonzero low nibble, and 0x40. A write to such an offset changes nothing.
- R2: Writing i < NUM_CPU to 0x20 raises `start_pulse[i]` for exactly one cycle, starting in the cycle after the write. In that cycle `start_pc` and `start_sp` hold the values last written to 0x30 and 0x70. Processor i becomes running and unpaused. A value i >= NUM_CPU is ignored.
- R3: Writing i to 0x50 pauses every processor other than i; if i >= NUM_CPU, it pauses all of them. Writing i to 0x60 clears the pause of processor i. `run_en` reflects the change one cycle after the write.
- R4: After reset only processor 0 is running; `run_en` is 4'b0001. A read of 0xD0 returns the number of clock edges since reset at which the requester's `run_en` bit was high.
- R5: A write to 0xA0 with nr in data[31:16] and the target in data[15:0] appends nr to the target's queue. A target >= NUM_CPU drops the send.
- R6: A write to 0xB0 in the same format appends nr to the queue of every processor except the named one. If the named one does not exist, it appends to all queues.
- R7: A send whose nr is 0 leaves every queue, interrupt line and overflow flag unchanged.
- R8: A read of 0xC0 returns and removes the oldest entry of the requester's own queue, in arrival order. If that queue is empty, the read returns 0.
- R9: `ipi_irq[i]` is high exactly while queue i holds at least one entry. It rises the cycle after an enqueue and falls the cycle after the read that empties the queue.
- R10: A write to 0xC0 empties only the requester's queue and clears only its overflow flag.
- R11: An enqueue to a queue already holding 8 entries is dropped and sets `ipi_ovf[i]`. The flag stays set until the owner flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | 8 | Byte offset of the register |
| req_cpu | input | 2 | Id of the processor making the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the access cycle |
| run_en | output | 4 | Per-processor run permission (running and not paused) |
| start_pulse | output | 4 | One-cycle release strobe per processor |
| start_pc | output | 32 | Boot address presented with the release strobe |
| start_sp | output | 32 | Boot stack presented with the release strobe |
| ipi_irq | output | 4 | Per-processor interrupt, high while its queue is not empty |
| ipi_ovf | output | 4 | Per-processor sticky queue overflow flag |

## Verification
A broadcast fans out to several queues in one cycle. When some targets are full and others are not, a dropped entry with its overflow flag set and an accepted entry with a rising interrupt land on the same edge. The bench fills one queue to eight entries and then broadcasts while excluding a different processor. Its queue model decides per target whether the entry lands or the flag sets, and it compares every line on the next clock. A second overlap is the registered release strobe meeting a following pause write in the very next cycle. The bench issues them back to back and checks that the released processor loses `run_en` one cycle after its strobe.

// File: rtl/mp_pkg.sv
package mp_pkg;

    localparam int BUS_DW   = 32;
    localparam int OFS_W    = 8;
    localparam int IPI_NR_W = 16;

    typedef enum logic [3:0] {
        SEL_WHOAMI   = 4'h0,
        SEL_NCPU     = 4'h1,
        SEL_START    = 4'h2,
        SEL_BOOTPC   = 4'h3,
        SEL_HOLD     = 4'h5,
        SEL_RESUME   = 4'h6,
        SEL_BOOTSP   = 4'h7,
        SEL_SEND_ONE = 4'hA,
        SEL_SEND_ALL = 4'hB,
        SEL_IPIQ     = 4'hC,
        SEL_CYCLES   = 4'hD
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } ofs_dec_t;

    typedef struct packed {
        logic [IPI_NR_W-1:0]          nr;
        logic [BUS_DW-IPI_NR_W-1:0]   tgt;
    } ipi_word_t;

    function automatic ofs_dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
        ofs_dec_t d;
        d.hit = 1'b0;
        d.sel = SEL_WHOAMI;
        if (ofs[3:0] == 4'h0) begin
            d.hit = 1'b1;
            case (ofs[7:4])
                4'h0:    d.sel = SEL_WHOAMI;
                4'h1:    d.sel = SEL_NCPU;
                4'h2:    d.sel = SEL_START;
                4'h3:    d.sel = SEL_BOOTPC;
                4'h5:    d.sel = SEL_HOLD;
                4'h6:    d.sel = SEL_RESUME;
                4'h7:    d.sel = SEL_BOOTSP;
                4'hA:    d.sel = SEL_SEND_ONE;
                4'hB:    d.sel = SEL_SEND_ALL;
                4'hC:    d.sel = SEL_IPIQ;
                4'hD:    d.sel = SEL_CYCLES;
                default: d.hit = 1'b0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mp_ipi_fifo.sv
module mp_ipi_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_nr,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             not_empty,
    output logic             ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             is_full, is_empty, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (fill_q == '0);
    assign is_full  = (fill_q == CNT_W'(DEPTH));
    assign do_push  = push && !is_full && !flush;
    assign do_pop   = pop && !is_empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_q[wr_ptr_q] <= push_nr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            fill_q   <= '0;
            ovf      <= 1'b0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
            if (push && is_full && !do_pop) ovf <= 1'b1;
        end
    end

    assign head      = slot_q[rd_ptr_q];
    assign not_empty = !is_empty;

endmodule

// File: rtl/mp_ipi_route.sv
module mp_ipi_route
    import mp_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               send_one,
    input  logic               send_all,
    input  ipi_word_t          cmd,
    output logic [NUM_CPU-1:0] push
);
    logic nr_valid;
    assign nr_valid = (cmd.nr != '0);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_tgt
        logic named;
        assign named   = (cmd.tgt == (BUS_DW - IPI_NR_W)'(g));
        assign push[g] = nr_valid && ((send_one && named) || (send_all && !named));
    end

endmodule

// File: rtl/mp_run_ctrl.sv
module mp_run_ctrl #(
    parameter int NUM_CPU = 4,
    parameter int DW      = 32,
    parameter int CYC_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_we,
    input  logic                          hold_we,
    input  logic                          resume_we,
    input  logic                          pc_we,
    input  logic                          sp_we,
    input  logic [DW-1:0]                 wdata,
    output logic [NUM_CPU-1:0]            run_en,
    output logic [NUM_CPU-1:0]            start_pulse,
    output logic [DW-1:0]                 start_pc,
    output logic [DW-1:0]                 start_sp,
    output logic [NUM_CPU-1:0][CYC_W-1:0] cyc_cnt
);
    logic [NUM_CPU-1:0] sel_vec;
    logic [NUM_CPU-1:0] running_q, held_q;
    logic [DW-1:0]      boot_pc_q, boot_sp_q;
    logic               sel_ok;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_sel
        assign sel_vec[g] = (wdata == DW'(g));
    end
    assign sel_ok = |sel_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q   <= NUM_CPU'(1);
            held_q      <= '0;
            start_pulse <= '0;
            start_pc    <= '0;
            start_sp    <= '0;
            boot_pc_q   <= '0;
            boot_sp_q   <= '0;
        end else begin
            start_pulse <= '0;
            if (pc_we) boot_pc_q <= wdata;
            if (sp_we) boot_sp_q <= wdata;
            if (start_we && sel_ok) begin
                start_pulse <= sel_vec;
                running_q   <= running_q | sel_vec;
                held_q      <= held_q & ~sel_vec;
                start_pc    <= boot_pc_q;
                start_sp    <= boot_sp_q;
            end
            if (hold_we)   held_q <= held_q | ~sel_vec;
            if (resume_we) held_q <= held_q & ~sel_vec;
        end
    end

    assign run_en = running_q & ~held_q;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cyc
        always_ff @(posedge clk) begin
            if (rst)            cyc_cnt[g] <= '0;
            else if (run_en[g]) cyc_cnt[g] <= cyc_cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
    import mp_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int IPI_DEPTH = 8,
    parameter int CYC_W     = 32,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [BUS_DW-1:0]  req_wdata,
    output logic [BUS_DW-1:0]  rd_data,
    output logic [NUM_CPU-1:0] run_en,
    output logic [NUM_CPU-1:0] start_pulse,
    output logic [BUS_DW-1:0]  start_pc,
    output logic [BUS_DW-1:0]  start_sp,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] ipi_ovf
);
    ofs_dec_t  dec;
    logic      wr_hit, rd_hit, cpu_ok;
    ipi_word_t cmd;
    logic [NUM_CPU-1:0]                push_vec, pop_vec, flush_vec;
    logic [NUM_CPU-1:0][IPI_NR_W-1:0]  head_vec;
    logic [NUM_CPU-1:0][CYC_W-1:0]     cyc_cnt;

    assign dec    = decode_ofs(req_ofs);
    assign wr_hit = req_valid && req_write && dec.hit;
    assign rd_hit = req_valid && !req_write && dec.hit;
    assign cpu_ok = (int'(req_cpu) < NUM_CPU);
    assign cmd    = ipi_word_t'(req_wdata);

    mp_run_ctrl #(
        .NUM_CPU (NUM_CPU),
        .DW      (BUS_DW),
        .CYC_W   (CYC_W)
    ) u_run (
        .clk         (clk),
        .rst         (rst),
        .start_we    (wr_hit && dec.sel == SEL_START),
        .hold_we     (wr_hit && dec.sel == SEL_HOLD),
        .resume_we   (wr_hit && dec.sel == SEL_RESUME),
        .pc_we       (wr_hit && dec.sel == SEL_BOOTPC),
        .sp_we       (wr_hit && dec.sel == SEL_BOOTSP),
        .wdata       (req_wdata),
        .run_en      (run_en),
        .start_pulse (start_pulse),
        .start_pc    (start_pc),
        .start_sp    (start_sp),
        .cyc_cnt     (cyc_cnt)
    );

    mp_ipi_route #(
        .NUM_CPU (NUM_CPU)
    ) u_route (
        .send_one (wr_hit && dec.sel == SEL_SEND_ONE),
        .send_all (wr_hit && dec.sel == SEL_SEND_ALL),
        .cmd      (cmd),
        .push     (push_vec)
    );

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_q
        logic own;
        assign own          = (req_cpu == CPU_W'(g)) && dec.sel == SEL_IPIQ;
        assign pop_vec[g]   = rd_hit && own;
        assign flush_vec[g] = wr_hit && own;

        mp_ipi_fifo #(
            .DEPTH (IPI_DEPTH),
            .WIDTH (IPI_NR_W)
        ) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (push_vec[g]),
            .push_nr   (cmd.nr),
            .pop       (pop_vec[g]),
            .flush     (flush_vec[g]),
            .head      (head_vec[g]),
            .not_empty (ipi_irq[g]),
            .ovf       (ipi_ovf[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit && cpu_ok) begin
            case (dec.sel)
                SEL_WHOAMI: rd_data = BUS_DW'(req_cpu);
                SEL_NCPU:   rd_data = BUS_DW'(NUM_CPU);
                SEL_IPIQ:   rd_data = ipi_irq[req_cpu] ? BUS_DW'(head_vec[req_cpu]) : '0;
                SEL_CYCLES: rd_data = BUS_DW'(cyc_cnt[req_cpu]);
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/mp_ctrl_chk.sv
module mp_ctrl_chk #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [7:0]         req_ofs,
    input logic [CPU_W-1:0]   req_cpu,
    input logic [31:0]        req_wdata,
    input logic [31:0]        rd_data,
    input logic [NUM_CPU-1:0] run_en,
    input logic [NUM_CPU-1:0] start_pulse,
    input logic [NUM_CPU-1:0] ipi_irq,
    input logic [NUM_CPU-1:0] ipi_ovf
);
    logic wr_at, rd_at;
    assign wr_at = req_valid && req_write;
    assign rd_at = req_valid && !req_write;

    AST_WHOAMI_ID: assert property (@(posedge clk) disable iff (rst)
        (rd_at && req_ofs == 8'h00) |-> rd_data == 32'(req_cpu)); // R1

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pulse)); // R2

    AST_ZERO_NR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_at && (req_ofs == 8'hA0 || req_ofs == 8'hB0) && req_wdata[31:16] == 16'h0)
        |=> ($stable(ipi_irq) && $stable(ipi_ovf))); // R7

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> run_en[g]); // R2

        AST_HOLD_OTHERS: assert property (@(posedge clk) disable iff (rst)
            (wr_at && req_ofs == 8'h50 && req_wdata != 32'(g)) |=> !run_en[g]); // R3

        AST_SEND_RAISES: assert property (@(posedge clk) disable iff (rst)
            (wr_at && req_ofs == 8'hA0 && req_wdata[31:16] != 16'h0 &&
             req_wdata[15:0] == 16'(g)) |=> ipi_irq[g]); // R5

        AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rd_at && req_ofs == 8'hC0 && req_cpu == CPU_W'(g) && !ipi_irq[g])
            |-> rd_data == 32'h0); // R8

        AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $fell(ipi_irq[g]) |-> $past(req_valid && req_ofs == 8'hC0 &&
                                        req_cpu == CPU_W'(g))); // R9

        AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (wr_at && req_ofs == 8'hC0 && req_cpu == CPU_W'(g))
            |=> (!ipi_irq[g] && !ipi_ovf[g])); // R10

        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ipi_ovf[g] && !(wr_at && req_ofs == 8'hC0 && req_cpu == CPU_W'(g)))
            |=> ipi_ovf[g]); // R11
    end

endmodule

bind mp_ctrl mp_ctrl_chk #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ofs     (req_ofs),
    .req_cpu     (req_cpu),
    .req_wdata   (req_wdata),
    .rd_data     (rd_data),
    .run_en      (run_en),
    .start_pulse (start_pulse),
    .ipi_irq     (ipi_irq),
    .ipi_ovf     (ipi_ovf)
);

// File: tb/mp_ctrl_tb.sv
module mp_ctrl_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_ofs = '0;
    logic [1:0]  req_cpu = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data, start_pc, start_sp;
    logic [N-1:0] run_en, start_pulse, ipi_irq, ipi_ovf;

    always #2 clk = ~clk;

    mp_ctrl u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_ofs (req_ofs), .req_cpu (req_cpu), .req_wdata (req_wdata),
        .rd_data (rd_data), .run_en (run_en), .start_pulse (start_pulse),
        .start_pc (start_pc), .start_sp (start_sp), .ipi_irq (ipi_irq),
        .ipi_ovf (ipi_ovf)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    int          mq [N][$];
    bit          m_ovf [N];
    bit          m_run [N];
    bit          m_hold [N];
    bit          m_pulse [N];
    logic [31:0] m_pc, m_sp, m_bpc, m_bsp;
    int unsigned m_cyc [N];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void m_push(input int t, input int nr);
        if (mq[t].size() == 8) m_ovf[t] = 1'b1;
        else mq[t].push_back(nr);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                mq[i].delete(); m_ovf[i] = 0; m_run[i] = (i == 0);
                m_hold[i] = 0; m_pulse[i] = 0; m_cyc[i] = 0;
            end
            m_pc = 0; m_sp = 0; m_bpc = 0; m_bsp = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_run[i] && !m_hold[i]) m_cyc[i]++;
                m_pulse[i] = 0;
            end
            if (req_valid && req_ofs[3:0] == 4'h0) begin
                int c, nr, tg;
                logic [31:0] w;
                c = int'(req_cpu); w = req_wdata;
                nr = int'(w[31:16]); tg = int'(w[15:0]);
                if (req_write) begin
                    case (req_ofs[7:4])
                        4'h2: if (w < N) begin
                            m_pulse[w] = 1; m_run[w] = 1; m_hold[w] = 0;
                            m_pc = m_bpc; m_sp = m_bsp;
                        end
                        4'h3: m_bpc = w;
                        4'h7: m_bsp = w;
                        4'h5: for (int i = 0; i < N; i++) if (w != i) m_hold[i] = 1;
                        4'h6: if (w < N) m_hold[w] = 0;
                        4'hA: if (nr != 0 && tg < N) m_push(tg, nr);
                        4'hB: if (nr != 0) for (int i = 0; i < N; i++) if (i != tg) m_push(i, nr);
                        4'hC: begin mq[c].delete(); m_ovf[c] = 0; end
                        default: ;
                    endcase
                end else if (req_ofs[7:4] == 4'hC && mq[c].size() > 0) begin
                    void'(mq[c].pop_front());
                end
            end
        end
    end

    // compare registered outputs against the model every cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                chk(32'(ipi_irq[i]), 32'(mq[i].size() != 0), "R9 irq");
                chk(32'(ipi_ovf[i]), 32'(m_ovf[i]), "R11 ovf");
                chk(32'(run_en[i]), 32'(m_run[i] && !m_hold[i]), "R3 run_en");
                chk(32'(start_pulse[i]), 32'(m_pulse[i]), "R2 pulse");
            end
            if (start_pulse != '0) begin
                chk(start_pc, m_pc, "R2 start_pc");
                chk(start_sp, m_sp, "R2 start_sp");
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] ofs, input int c);
        if (ofs[3:0] != 4'h0) return 32'h0;
        case (ofs[7:4])
            4'h0: return 32'(c);
            4'h1: return 32'(N);
            4'hC: return (mq[c].size() > 0) ? 32'(mq[c][0]) : 32'h0;
            4'hD: return m_cyc[c];
            default: return 32'h0;
        endcase
    endfunction

    task automatic acc(input bit wr, input int c, input logic [7:0] ofs,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cpu = 2'(c);
        req_ofs = ofs; req_wdata = d;
        #1;
        if (!wr) chk(rd_data, exp_rd(ofs, c), tag);
    endtask

    task automatic rd_lit(input int c, input logic [7:0] ofs,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = 2'(c);
        req_ofs = ofs; req_wdata = '0;
        #1;
        chk(rd_data, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        chk(32'(run_en), 32'h1, "R4 reset run_en");
        chk(32'(ipi_irq), 32'h0, "R9 reset irq");
        rd_lit(1, 8'hD0, 32'h0, "R4 cycles idle cpu");

        // identity and undecoded offsets
        for (int c = 0; c < N; c++) acc(0, c, 8'h00, 0, "R1 whoami");
        rd_lit(2, 8'h10, 32'd4, "R1 ncpus");
        acc(0, 0, 8'h04, 0, "R1 unaligned read");
        acc(0, 0, 8'h40, 0, "R1 undecoded read");
        acc(1, 0, 8'h24, 32'd1, "R1 unaligned write");
        idle(2);

        // release with boot values, then hold in the very next cycle
        acc(1, 0, 8'h30, 32'h0000_1000, "R2");
        acc(1, 0, 8'h70, 32'h0000_2000, "R2");
        acc(1, 0, 8'h20, 32'd2, "R2 start");
        acc(1, 0, 8'h50, 32'd1, "R3 hold others");
        idle(2);
        acc(1, 0, 8'h20, 32'd7, "R2 out of range start");
        acc(1, 0, 8'h60, 32'd0, "R3 resume 0");
        acc(1, 0, 8'h20, 32'd3, "R2 start 3");
        acc(1, 3, 8'h60, 32'd2, "R3 resume 2");
        idle(3);
        for (int c = 0; c < N; c++) acc(0, c, 8'hD0, 0, "R4 cycles");

        // unicast, zero number, broadcast
        acc(1, 0, 8'hA0, {16'd5, 16'd1}, "R5 unicast");
        acc(1, 0, 8'hA0, {16'd0, 16'd1}, "R7 zero nr");
        acc(1, 0, 8'hB0, {16'd0, 16'd2}, "R7 zero nr bcast");
        acc(1, 0, 8'hA0, {16'd6, 16'd9}, "R5 bad target");
        acc(1, 2, 8'hB0, {16'd9, 16'd1}, "R6 bcast");
        idle(1);
        rd_lit(1, 8'hC0, 32'd5, "R8 first pop");
        rd_lit(1, 8'hC0, 32'd0, "R8 empty pop");
        rd_lit(0, 8'hC0, 32'd9, "R6 bcast landed");
        acc(0, 0, 8'hC0, 0, "R8 empty after");

        // fill cpu3 (holds 9 already) past depth
        for (int k = 0; k < 8; k++) acc(1, 1, 8'hA0, {16'(100 + k), 16'd3}, "R11 fill");
        idle(1);
        chk(32'(ipi_ovf), 32'h8, "R11 overflow flag");
        // broadcast hits full cpu3 and open cpu1/cpu2 in the same cycle
        acc(1, 1, 8'hB0, {16'h77, 16'd0}, "R6 mixed bcast");
        idle(1);
        rd_lit(3, 8'hC0, 32'd9, "R8 order 0");
        for (int k = 0; k < 7; k++) rd_lit(3, 8'hC0, 32'(100 + k), "R8 order");
        rd_lit(3, 8'hC0, 32'd0, "R8 drained");
        idle(1);
        chk(32'(ipi_ovf[3]), 32'h1, "R11 sticky after drain");
        acc(1, 3, 8'hC0, 0, "R10 flush 3");
        acc(1, 2, 8'hC0, 0, "R10 flush 2");
        idle(1);
        chk(32'(ipi_irq), 32'h2, "R10 only own queue");
        rd_lit(1, 8'hC0, 32'h77, "R10 other kept");
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule